// File: doc/BRIEF.md
# Synchronous Slave Serial Transmitter

This block sends characters over a two-wire synchronous link in which the far end is the clock master. The host loads a character into a holding register. The block moves it into a shift register and presents one bit at a time on its data output. Each new bit appears on the edge of the external clock on which the master does not sample. The external clock is brought into the system clock domain through a synchroniser, and an edge detector picks out the edge on which data may change. A polarity input selects which of the two edges that is.

The block keeps up to two characters: one being shifted and one waiting. A buffer-empty flag reports whether the holding register can take another word. A shift-empty flag reports whether anything is on the line. The block keeps shifting while the host core is halted. Its wake request, qualified by two enables, can bring the core out of sleep. A further global enable turns the wake request into a service request. Characters are 8 bits, or 9 bits when the ninth bit is supplied on a separate input at the time of the write.

Top module: `sst_tx`

## Requirements
- R1: `dout_oe` is 1 only when `sync_sel`=1, `master_sel`=0, `rx_once_en`=0, `rx_cont_en`=0, `port_en`=1 and `tx_en`=1. Setting either receive enable, or setting `master_sel`, drops it to 0.
- R2: A write while `dout_oe` is 0 is ignored. `shift_empty` and `buf_empty` stay 1, and no character is sent after transmission is enabled again.
- R3: A write while `shift_empty` is 1 loads the character straight into the shift register. In the next cycle `shift_empty` is 0, `buf_empty` is still 1, and `dout` shows data bit 0.
- R4: Bits leave least significant first, one per change edge of `ext_ck`. With `ck_pol`=0 the line idles low and data changes on its falling edge. With `ck_pol`=1 it idles high and data changes on its rising edge. `dout` holds steady across the opposite (sampling) edge.
- R5: When `nine_sel`=1 at the time of a write, the character is 9 bits long. The ninth bit is the value of `ninth_bit` at that write, and it is sent after data bit 7.
- R6: A write while a character is shifting and the holding register is empty stores the word in the holding register. `buf_empty` goes to 0 and stays 0 until that character ends.
- R7: When the last bit of a character has been shifted, a held word moves into the shift register. At that moment `buf_empty` returns to 1, `shift_empty` stays 0, and the held word is sent back to back.
- R8: After the last character ends with nothing held, `shift_empty` is 1 and `dout` idles at 1.
- R9: `wake_req` is 1 exactly when `buf_empty`, `periph_ie` and `tx_ie` are all 1.
- R10: `isr_req` is 1 exactly when `wake_req` and `global_ie` are both 1.
- R11: Clearing `tx_en` or `port_en` abandons any transfer. In the next cycle both `buf_empty` and `shift_empty` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_sel | input | 1 | Synchronous mode select |
| master_sel | input | 1 | 1 selects clock master; must be 0 for this mode |
| rx_once_en | input | 1 | Single-character receive enable |
| rx_cont_en | input | 1 | Continuous receive enable |
| port_en | input | 1 | Serial port enable |
| tx_en | input | 1 | Transmit enable |
| nine_sel | input | 1 | 9-bit character select, taken at write |
| ninth_bit | input | 1 | Ninth data bit, taken at write |
| ck_pol | input | 1 | External clock polarity / change-edge select |
| wr_stb | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | DATA_W | Low data bits of the character |
| ext_ck | input | 1 | Clock driven by the external master |
| periph_ie | input | 1 | Peripheral interrupt enable |
| tx_ie | input | 1 | Transmit interrupt enable |
| global_ie | input | 1 | Global interrupt enable |
| dout | output | 1 | Serial data line |
| dout_oe | output | 1 | Data line drive enable (mode active) |
| buf_empty | output | 1 | Holding register can accept a word |
| shift_empty | output | 1 | No character in the shift register |
| wake_req | output | 1 | Wake request from buffer-empty |
| isr_req | output | 1 | Interrupt service request |

## Verification
The bench plays the master. It toggles `ext_ck` slowly and, after every sampling edge, compares `dout` with the bits that the write task queued. The bench goes after the second write during shifting. A design that let that write overwrite the shift register would corrupt the first character, and one that raised `buf_empty` early would show the flag during the first character. It checks the handover at the end of a character. A design that got this wrong would drop the held word, or insert an idle gap that shifts every following bit by one. It runs a 9-bit character whose ninth bit is the only 1, and both clock polarities, where a wrong edge choice moves the data onto the sampling edge. It aborts with each enable while both registers are full, where a design that failed to clear would resume sending a stale word.

// File: rtl/sst_pkg.sv
package sst_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_SLV_TX = 2'd1,
        MODE_SLV_RX = 2'd2,
        MODE_MASTER = 2'd3
    } sst_mode_e;

    typedef struct packed {
        logic sync_sel;
        logic master_sel;
        logic rx_once;
        logic rx_cont;
        logic port_on;
    } sst_ctrl_t;

    // Mode priority: port/sync off, then master, then any receive enable.
    function automatic sst_mode_e decode_mode(sst_ctrl_t c);
        if (!c.port_on || !c.sync_sel) return MODE_IDLE;
        if (c.master_sel)              return MODE_MASTER;
        if (c.rx_once || c.rx_cont)    return MODE_SLV_RX;
        return MODE_SLV_TX;
    endfunction

    // Polarity 0: data changes on the falling edge; polarity 1: on the rising edge.
    function automatic logic change_edge(logic pol, logic rise, logic fall);
        return pol ? rise : fall;
    endfunction

endpackage

// File: rtl/sst_edge_sync.sv
module sst_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_ck,
    input  logic ck_pol,
    output logic shift_pulse
);
    import sst_pkg::*;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              level;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], ext_ck};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign level       = sync_q[STAGES-1];
    assign shift_pulse = change_edge(ck_pol, level & ~prev_q, ~level & prev_q);

endmodule

// File: rtl/sst_tx_core.sv
module sst_tx_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              shift_pulse,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              nine_sel,
    input  logic              ninth_bit,
    output logic              line_bit,
    output logic              hold_full,
    output logic              busy
);
    localparam int CHAR_W = DATA_W + 1;
    localparam int CNT_W  = $clog2(CHAR_W + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  nbits;
        logic [CHAR_W-1:0] bits;
    } sst_word_t;

    sst_word_t         hold_q;
    sst_word_t         new_w;
    logic              hold_full_q;
    logic [CHAR_W-1:0] shreg_q;
    logic [CNT_W-1:0]  left_q;
    logic              busy_q;
    logic              done;
    logic              step;

    always_comb begin
        new_w.bits  = {ninth_bit & nine_sel, wr_data};
        new_w.nbits = nine_sel ? CNT_W'(CHAR_W) : CNT_W'(DATA_W);
    end

    assign done = busy_q & shift_pulse & (left_q == CNT_W'(1));
    assign step = busy_q & shift_pulse & (left_q != CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
            shreg_q     <= '0;
            left_q      <= '0;
            busy_q      <= 1'b0;
        end else if (hold_full_q) begin
            if (done) begin
                shreg_q     <= hold_q.bits;
                left_q      <= hold_q.nbits;
                hold_full_q <= wr_stb;
                if (wr_stb) hold_q <= new_w;
            end else begin
                if (step) begin
                    shreg_q <= shreg_q >> 1;
                    left_q  <= left_q - CNT_W'(1);
                end
                if (wr_stb) hold_q <= new_w;
            end
        end else if (wr_stb && (!busy_q || done)) begin
            shreg_q <= new_w.bits;
            left_q  <= new_w.nbits;
            busy_q  <= 1'b1;
        end else begin
            if (wr_stb) begin
                hold_q      <= new_w;
                hold_full_q <= 1'b1;
            end
            if (done) busy_q <= 1'b0;
            if (step) begin
                shreg_q <= shreg_q >> 1;
                left_q  <= left_q - CNT_W'(1);
            end
        end
    end

    assign line_bit  = busy_q ? shreg_q[0] : 1'b1;
    assign hold_full = hold_full_q;
    assign busy      = busy_q;

endmodule

// File: rtl/sst_irq.sv
module sst_irq (
    input  logic buf_empty,
    input  logic periph_ie,
    input  logic tx_ie,
    input  logic global_ie,
    output logic wake_req,
    output logic isr_req
);
    logic wake;

    assign wake     = buf_empty & periph_ie & tx_ie;
    assign wake_req = wake;
    assign isr_req  = wake & global_ie;

endmodule

// File: rtl/sst_tx.sv
module sst_tx #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_sel,
    input  logic              master_sel,
    input  logic              rx_once_en,
    input  logic              rx_cont_en,
    input  logic              port_en,
    input  logic              tx_en,
    input  logic              nine_sel,
    input  logic              ninth_bit,
    input  logic              ck_pol,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_ck,
    input  logic              periph_ie,
    input  logic              tx_ie,
    input  logic              global_ie,
    output logic              dout,
    output logic              dout_oe,
    output logic              buf_empty,
    output logic              shift_empty,
    output logic              wake_req,
    output logic              isr_req
);
    import sst_pkg::*;

    sst_ctrl_t ctrl;
    sst_mode_e mode;
    logic      active;
    logic      shift_pulse;
    logic      hold_full;
    logic      busy;

    always_comb begin
        ctrl.sync_sel   = sync_sel;
        ctrl.master_sel = master_sel;
        ctrl.rx_once    = rx_once_en;
        ctrl.rx_cont    = rx_cont_en;
        ctrl.port_on    = port_en;
        mode            = decode_mode(ctrl);
    end

    assign active = (mode == MODE_SLV_TX) && tx_en;

    sst_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .ext_ck      (ext_ck),
        .ck_pol      (ck_pol),
        .shift_pulse (shift_pulse)
    );

    sst_tx_core #(.DATA_W(DATA_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .active      (active),
        .shift_pulse (shift_pulse),
        .wr_stb      (wr_stb),
        .wr_data     (wr_data),
        .nine_sel    (nine_sel),
        .ninth_bit   (ninth_bit),
        .line_bit    (dout),
        .hold_full   (hold_full),
        .busy        (busy)
    );

    assign dout_oe     = active;
    assign buf_empty   = ~hold_full;
    assign shift_empty = ~busy;

    sst_irq u_irq (
        .buf_empty (buf_empty),
        .periph_ie (periph_ie),
        .tx_ie     (tx_ie),
        .global_ie (global_ie),
        .wake_req  (wake_req),
        .isr_req   (isr_req)
    );

endmodule

// File: rtl/sst_tx_chk.sv
module sst_tx_chk (
    input logic clk,
    input logic rst,
    input logic sync_sel,
    input logic master_sel,
    input logic rx_once_en,
    input logic rx_cont_en,
    input logic port_en,
    input logic tx_en,
    input logic wr_stb,
    input logic periph_ie,
    input logic tx_ie,
    input logic global_ie,
    input logic dout,
    input logic dout_oe,
    input logic buf_empty,
    input logic shift_empty,
    input logic wake_req,
    input logic isr_req
);
    // R1
    oe_mode_chk: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> (sync_sel && !master_sel && !rx_once_en && !rx_cont_en && port_en && tx_en));

    // R2
    idle_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!dout_oe && wr_stb) |=> (shift_empty && buf_empty));

    // R3
    direct_load_chk: assert property (@(posedge clk) disable iff (rst)
        (dout_oe && wr_stb && shift_empty) |=> (!shift_empty && buf_empty));

    // R6
    hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !buf_empty |-> !shift_empty);

    // R8
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        shift_empty |-> dout);

    // R9
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (buf_empty && periph_ie && tx_ie));

    // R10
    isr_chk: assert property (@(posedge clk) disable iff (rst)
        isr_req |-> (wake_req && global_ie));

    // R11
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_en || !port_en) |=> (buf_empty && shift_empty));

endmodule

bind sst_tx sst_tx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sync_sel    (sync_sel),
    .master_sel  (master_sel),
    .rx_once_en  (rx_once_en),
    .rx_cont_en  (rx_cont_en),
    .port_en     (port_en),
    .tx_en       (tx_en),
    .wr_stb      (wr_stb),
    .periph_ie   (periph_ie),
    .tx_ie       (tx_ie),
    .global_ie   (global_ie),
    .dout        (dout),
    .dout_oe     (dout_oe),
    .buf_empty   (buf_empty),
    .shift_empty (shift_empty),
    .wake_req    (wake_req),
    .isr_req     (isr_req)
);

// File: tb/sst_tx_bench.sv
module sst_tx_bench;
    localparam int DATA_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_sel = 1'b1, master_sel = 1'b0, rx_once_en = 1'b0, rx_cont_en = 1'b0;
    logic port_en = 1'b1, tx_en = 1'b0, nine_sel = 1'b0, ninth_bit = 1'b0, ck_pol = 1'b0;
    logic wr_stb = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic ext_ck = 1'b0;
    logic periph_ie = 1'b0, tx_ie = 1'b0, global_ie = 1'b0;
    logic dout, dout_oe, buf_empty, shift_empty, wake_req, isr_req;

    int checks = 0;
    int errors = 0;
    logic exp_q[$];
    string cur_req = "R4";
    event sample_ev;

    always #4 clk = ~clk;

    sst_tx #(.DATA_W(DATA_W), .SYNC_STAGES(2)) u_sst_tx (.*);

    task automatic chk(string req, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, expv, $time);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: writes a character and queues its bits when the block should accept it.
    task automatic put_char(logic [DATA_W-1:0] d, logic nine, logic b9, bit accept);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = d; nine_sel = nine; ninth_bit = b9;
        if (accept) begin
            for (int i = 0; i < DATA_W; i++) exp_q.push_back(d[i]);
            if (nine) exp_q.push_back(b9);
        end
        @(negedge clk);
        wr_stb = 1'b0; nine_sel = 1'b0; ninth_bit = 1'b0;
    endtask

    // Master: sampling edge, then change edge.
    task automatic master_bits(int n);
        for (int i = 0; i < n; i++) begin
            ext_ck = ~ck_pol;
            cyc(6);
            ->sample_ev;
            cyc(1);
            ext_ck = ck_pol;
            cyc(6);
        end
    endtask

    // Monitor: compares each sampled bit with the scoreboard.
    always begin
        @(sample_ev);
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL %s: actual bit %0b expected none (queue empty)", cur_req, dout);
        end else begin
            logic e;
            e = exp_q.pop_front();
            if (dout !== e) begin
                errors++;
                $display("FAIL %s: actual bit %0b expected %0b", cur_req, dout, e);
            end
        end
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // reset state
        chk("R8 reset shift_empty", shift_empty, 1'b1);
        chk("R6 reset buf_empty", buf_empty, 1'b1);
        chk("R9 reset wake", wake_req, 1'b0);
        chk("R1 reset oe", dout_oe, 1'b0);

        // R2: write while disabled
        put_char(8'hFF, 1'b0, 1'b0, 1'b0);
        chk("R2 ignored shift_empty", shift_empty, 1'b1);
        chk("R2 ignored buf_empty", buf_empty, 1'b1);

        // R1 mode decode
        tx_en = 1'b1; cyc(1);
        chk("R1 slave tx oe", dout_oe, 1'b1);
        rx_once_en = 1'b1; cyc(1);
        chk("R1 single rx blocks", dout_oe, 1'b0);
        rx_once_en = 1'b0; rx_cont_en = 1'b1; cyc(1);
        chk("R1 cont rx blocks", dout_oe, 1'b0);
        rx_cont_en = 1'b0; master_sel = 1'b1; cyc(1);
        chk("R1 master blocks", dout_oe, 1'b0);
        master_sel = 1'b0; cyc(1);
        chk("R2 nothing pending", shift_empty, 1'b1);

        // R3, R6, R7, R8, R4 with ck_pol = 0
        cur_req = "R4";
        put_char(8'hA5, 1'b0, 1'b0, 1'b1);
        chk("R3 shift_empty low", shift_empty, 1'b0);
        chk("R3 buf_empty high", buf_empty, 1'b1);
        chk("R3 dout bit0", dout, 1'b1);
        put_char(8'h3C, 1'b0, 1'b0, 1'b1);
        chk("R6 buf_empty low", buf_empty, 1'b0);
        master_bits(7);
        chk("R6 still held", buf_empty, 1'b0);
        cur_req = "R7";
        master_bits(1);
        chk("R7 buf_empty high", buf_empty, 1'b1);
        chk("R7 shift_empty low", shift_empty, 1'b0);
        master_bits(8);
        chk("R8 shift_empty high", shift_empty, 1'b1);
        chk("R8 dout idle", dout, 1'b1);
        chk("R7 queue drained", exp_q.size() == 0, 1'b1);

        // R5: 9-bit character
        cur_req = "R5";
        put_char(8'h00, 1'b1, 1'b1, 1'b1);
        master_bits(8);
        chk("R5 ninth pending", shift_empty, 1'b0);
        master_bits(1);
        chk("R5 done", shift_empty, 1'b1);
        chk("R5 queue drained", exp_q.size() == 0, 1'b1);

        // R4: ck_pol = 1
        cur_req = "R4";
        ck_pol = 1'b1; ext_ck = 1'b1; cyc(6);
        put_char(8'h96, 1'b0, 1'b0, 1'b1);
        master_bits(8);
        chk("R4 pol1 done", shift_empty, 1'b1);
        chk("R4 queue drained", exp_q.size() == 0, 1'b1);

        // R9, R10
        periph_ie = 1'b1; cyc(1);
        chk("R9 tx_ie off", wake_req, 1'b0);
        tx_ie = 1'b1; cyc(1);
        chk("R9 wake on", wake_req, 1'b1);
        chk("R10 no global", isr_req, 1'b0);
        global_ie = 1'b1; cyc(1);
        chk("R10 isr on", isr_req, 1'b1);
        put_char(8'h11, 1'b0, 1'b0, 1'b0);
        put_char(8'h22, 1'b0, 1'b0, 1'b0);
        chk("R9 full no wake", wake_req, 1'b0);
        chk("R10 full no isr", isr_req, 1'b0);

        // R11: abort via tx_en
        @(negedge clk); tx_en = 1'b0;
        @(negedge clk);
        chk("R11 tx_en buf_empty", buf_empty, 1'b1);
        chk("R11 tx_en shift_empty", shift_empty, 1'b1);
        tx_en = 1'b1; cyc(2);
        chk("R11 no resume", shift_empty, 1'b1);

        // R11: abort via port_en
        put_char(8'h33, 1'b0, 1'b0, 1'b0);
        put_char(8'h44, 1'b0, 1'b0, 1'b0);
        chk("R6 second held", buf_empty, 1'b0);
        @(negedge clk); port_en = 1'b0;
        @(negedge clk);
        chk("R11 port_en buf_empty", buf_empty, 1'b1);
        chk("R11 port_en shift_empty", shift_empty, 1'b1);
        port_en = 1'b1; cyc(2);
        chk("R11 port back idle", shift_empty, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule